// File: doc/BRIEF.md
# Sixteen-Times Polyphase Interpolation Filter

This block raises the sample rate of a stereo PCM stream by a factor of sixteen. Each accepted input frame (one left and one right sample) produces sixteen output samples for each channel. Each output sample is one phase of a long prototype low-pass FIR. All arithmetic runs on a single fast core clock. One multiply-accumulate unit is shared in time over every tap of every phase and over both channels. The coefficients live in an on-chip simple dual-port RAM that infers as block RAM. The recent input history for each channel sits in a circular buffer of the same kind.

Frames arrive from the read side of a clock-crossing FIFO, which lies outside this block. The block pops one frame when it is idle and then stays busy until all 32 results for that frame have left. The coefficient RAM has a plain write port so that an outside loader can fill it while the core is idle. Scaling for headroom is applied to the coefficient values, not in the datapath. The full-size configuration is 8192 taps (512 per phase). The default parameters use a short filter so that simulation stays quick.

Top module: `interp16_fir`

## Requirements
- R1: During reset and the clear pass that follows, `out_valid` and `in_ready` are low. The clear pass zeroes both history buffers and lasts BRANCH cycles. `in_ready` then rises, and all history older than the first accepted frame counts as zero.
- R2: Each accepted frame yields exactly 32 `out_valid` strobes, one per cycle, ordered phase 0 to RATIO-1. Within each phase the left result comes first (`out_chan`=0) and the right result second (`out_chan`=1). `out_phase` carries the phase number.
- R3: The result for phase p is the sum over k=0..BRANCH-1 of coef[p+RATIO*k]·x[n-k], where x[n] is the newest sample of that channel. Coefficients are signed with CW-1 fraction bits. The sum is rounded by adding 2^(CW-2) and shifting right arithmetically by CW-1.
- R4: A rounded sum above 2^(DW-1)-1 is output as 2^(DW-1)-1, and a sum below -2^(DW-1) is output as -2^(DW-1).
- R5: `in_ready` is low from the accepting edge until after the 32nd strobe of that frame. It is high again at the first clock edge following that strobe.
- R6: `in_valid` while `in_ready` is low neither pops nor stores a sample, and it produces no extra strobes.
- R7: The 32nd strobe of a frame appears exactly 2·RATIO·BRANCH+2 clock edges after the edge that accepted the frame.
- R8: A coefficient written through the write port while the core is idle is used by every later frame at address p+RATIO·k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | FIFO read side holds a frame |
| in_left | input | DW | Left input sample, signed |
| in_right | input | DW | Right input sample, signed |
| in_ready | output | 1 | Frame is popped when high together with in_valid |
| coef_we | input | 1 | Coefficient RAM write enable |
| coef_waddr | input | log2(TAPS) | Coefficient write address |
| coef_wdata | input | CW | Coefficient value, signed |
| out_valid | output | 1 | One result present this cycle |
| out_chan | output | 1 | 0 left, 1 right |
| out_phase | output | log2(RATIO) | Phase of the result |
| out_data | output | DW | Rounded, saturated result |

## Verification
A wrong history pointer or tap index corrupts the sum for every phase, so the first frame after a non-trivial one shows a mismatch on its first strobe. An off-by-one sequencing error moves the tag order or the 32nd strobe from edge 2·RATIO·BRANCH+2. The bench's tag and latency checks catch this during the first frame. Rounding and saturation errors show only when the sums land on half steps or reach the rails, so the bench fills the history with extreme samples under a large coefficient set. A frame popped while busy shifts the history, and the frame after it then mismatches.

// File: rtl/interp_pkg.sv
package interp_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/interp_coef_ram.sv
module interp_coef_ram #(
  parameter int AW = 7,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/interp_hist_ram.sv
module interp_hist_ram #(
  parameter int AW = 3,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/interp_mac.sv
module interp_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ACCW = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          first,
  input  logic          last,
  input  logic [CW-1:0] coef,
  input  logic [DW-1:0] sample,
  output logic          done,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  localparam int PW = DW + CW;
  localparam logic signed [ACCW-1:0] RND  = ACCW'(1) <<< (CW - 2);
  localparam logic signed [ACCW-1:0] MAXV = (ACCW'(1) <<< (DW - 1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] MINV = -(ACCW'(1) <<< (DW - 1));

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_x;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] rounded;
  logic        [DW-1:0]   clipped;

  assign prod    = $signed(coef) * $signed(sample);
  assign prod_x  = {{(ACCW-PW){prod[PW-1]}}, prod};
  assign rounded = (acc + RND) >>> (CW - 1);

  always_comb begin
    if (rounded > MAXV)      clipped = MAXV[DW-1:0];
    else if (rounded < MINV) clipped = MINV[DW-1:0];
    else                     clipped = rounded[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      done      <= valid && last;
      res_valid <= done;
      if (valid) acc <= (first ? '0 : acc) + prod_x;
      if (done) res_data <= clipped;
    end
  end
endmodule

// File: rtl/interp16_fir.sv
module interp16_fir #(
  parameter int RATIO = 16,
  parameter int TAPS  = 128,
  parameter int DW    = 16,
  parameter int CW    = 16,
  localparam int PW   = $clog2(RATIO),
  localparam int TW   = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          in_ready,
  input  logic          coef_we,
  input  logic [TW-1:0] coef_waddr,
  input  logic [CW-1:0] coef_wdata,
  output logic          out_valid,
  output logic          out_chan,
  output logic [PW-1:0] out_phase,
  output logic [DW-1:0] out_data
);
  import interp_pkg::*;

  localparam int BRANCH = TAPS / RATIO;
  localparam int BW     = $clog2(BRANCH);
  localparam int ACCW   = DW + CW + BW + 1;
  localparam logic [BW-1:0] K_LAST = BW'(BRANCH - 1);
  localparam logic [PW-1:0] P_LAST = PW'(RATIO - 1);

  seq_state_t    state;
  logic [BW-1:0] wptr, clr_idx, k;
  logic [PW-1:0] phase;
  logic          chan;
  logic          accept, issue;

  logic          hist_we;
  logic [BW-1:0] hist_waddr, hist_raddr;
  logic [DW-1:0] hist_wdata [2];
  logic [DW-1:0] hist_rdata [2];
  logic [TW-1:0] coef_raddr;
  logic [CW-1:0] coef_rdata;

  logic          s1_v, s1_first, s1_last, s1_chan;
  logic [PW-1:0] s1_phase;
  logic          s2_chan;
  logic [PW-1:0] s2_phase;
  logic          mac_done;

  assign in_ready   = (state == ST_IDLE);
  assign accept     = in_ready && in_valid;
  assign issue      = (state == ST_RUN);
  assign hist_we    = (state == ST_CLEAR) || accept;
  assign hist_waddr = (state == ST_CLEAR) ? clr_idx : wptr + BW'(1);
  assign hist_wdata[0] = (state == ST_CLEAR) ? '0 : in_left;
  assign hist_wdata[1] = (state == ST_CLEAR) ? '0 : in_right;
  assign hist_raddr = wptr - k;
  assign coef_raddr = {k, phase};

  // sequencer: tap counter innermost, then channel, then phase
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_CLEAR;
      wptr    <= '0;
      clr_idx <= '0;
      k       <= '0;
      phase   <= '0;
      chan    <= 1'b0;
    end else begin
      case (state)
        ST_CLEAR: begin
          clr_idx <= clr_idx + BW'(1);
          if (clr_idx == K_LAST) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (in_valid) begin
            wptr  <= wptr + BW'(1);
            k     <= '0;
            phase <= '0;
            chan  <= 1'b0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          k <= k + BW'(1);
          if (k == K_LAST) begin
            chan <= ~chan;
            if (chan) begin
              phase <= phase + PW'(1);
              if (phase == P_LAST) state <= ST_DRAIN;
            end
          end
        end
        default: begin
          if (out_valid && out_chan && (out_phase == P_LAST)) state <= ST_IDLE;
        end
      endcase
    end
  end

  interp_coef_ram #(.AW(TW), .W(CW)) u_coef (
    .clk   (clk),
    .we    (coef_we),
    .waddr (coef_waddr),
    .wdata (coef_wdata),
    .raddr (coef_raddr),
    .rdata (coef_rdata)
  );

  for (genvar c = 0; c < 2; c++) begin : g_hist
    interp_hist_ram #(.AW(BW), .W(DW)) u_hist (
      .clk   (clk),
      .we    (hist_we),
      .waddr (hist_waddr),
      .wdata (hist_wdata[c]),
      .raddr (hist_raddr),
      .rdata (hist_rdata[c])
    );
  end

  // tags aligned with the RAM read data, then with the MAC result
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_first  <= 1'b0;
      s1_last   <= 1'b0;
      s1_chan   <= 1'b0;
      s1_phase  <= '0;
      s2_chan   <= 1'b0;
      s2_phase  <= '0;
      out_chan  <= 1'b0;
      out_phase <= '0;
    end else begin
      s1_v     <= issue;
      s1_first <= issue && (k == '0);
      s1_last  <= issue && (k == K_LAST);
      s1_chan  <= chan;
      s1_phase <= phase;
      if (s1_v && s1_last) begin
        s2_chan  <= s1_chan;
        s2_phase <= s1_phase;
      end
      if (mac_done) begin
        out_chan  <= s2_chan;
        out_phase <= s2_phase;
      end
    end
  end

  interp_mac #(.DW(DW), .CW(CW), .ACCW(ACCW)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .valid     (s1_v),
    .first     (s1_first),
    .last      (s1_last),
    .coef      (coef_rdata),
    .sample    (s1_chan ? hist_rdata[1] : hist_rdata[0]),
    .done      (mac_done),
    .res_valid (out_valid),
    .res_data  (out_data)
  );
endmodule

// File: rtl/interp16_fir_chk.sv
module interp16_fir_chk #(
  parameter int RATIO = 16,
  localparam int PW   = $clog2(RATIO)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_chan,
  input logic [PW-1:0] out_phase
);
  logic [PW:0] cnt;
  logic        busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (in_valid && in_ready) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (out_valid) begin
      cnt <= cnt + 1'b1;
      if (cnt == (PW+1)'(2*RATIO-1)) busy <= 1'b0;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!out_valid && !in_ready));
  p_tag_order_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({out_phase, out_chan} == cnt));
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);
  p_pop_then_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  p_no_stray_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
endmodule

bind interp16_fir interp16_fir_chk #(.RATIO(RATIO)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_chan  (out_chan),
  .out_phase (out_phase)
);

// File: tb/sim_interp16_fir.sv
module sim_interp16_fir;
  localparam int RATIO  = 16;
  localparam int TAPS   = 128;
  localparam int DW     = 16;
  localparam int CW     = 16;
  localparam int BRANCH = TAPS / RATIO;
  localparam int PW     = $clog2(RATIO);
  localparam int TW     = $clog2(TAPS);
  localparam int LAT    = 2 * RATIO * BRANCH + 2;
  localparam int NV     = 12;
  // stimulus: {left, right, coefficient set (0 small, 1 large), junk while busy}
  localparam logic [33:0] VEC [NV] = '{
    {16'sd1000,   -16'sd1000,  1'b0, 1'b0},
    {16'sd0,      16'sd0,      1'b0, 1'b0},
    {16'sd12345,  -16'sd2222,  1'b0, 1'b1},
    {16'sd32767,  -16'sd32768, 1'b0, 1'b0},
    {-16'sd7,     16'sd3,      1'b0, 1'b1},
    {16'sd500,    16'sd500,    1'b0, 1'b0},
    {16'sd32767,  -16'sd32768, 1'b1, 1'b0},
    {16'sd32767,  -16'sd32768, 1'b1, 1'b0},
    {16'sd32767,  -16'sd32768, 1'b1, 1'b0},
    {-16'sd32768, 16'sd32767,  1'b1, 1'b1},
    {-16'sd32768, 16'sd32767,  1'b1, 1'b0},
    {16'sd1,      -16'sd1,     1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_left = '0, in_right = '0;
  logic          in_ready;
  logic          coef_we = 1'b0;
  logic [TW-1:0] coef_waddr = '0;
  logic [CW-1:0] coef_wdata = '0;
  logic          out_valid, out_chan;
  logic [PW-1:0] out_phase;
  logic [DW-1:0] out_data;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  longint hl [BRANCH];
  longint hr [BRANCH];
  longint cf [TAPS];

  always #5 clk = ~clk;

  interp16_fir #(.RATIO(RATIO), .TAPS(TAPS), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .in_ready(in_ready), .coef_we(coef_we),
    .coef_waddr(coef_waddr), .coef_wdata(coef_wdata), .out_valid(out_valid),
    .out_chan(out_chan), .out_phase(out_phase), .out_data(out_data)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_coefs(input bit big);
    for (int i = 0; i < TAPS; i++) begin
      @(negedge clk);
      cf[i] = big ? 32767 - 3 * i : (((i * 73 + 5) % 256) - 128) * 40;
      coef_we = 1'b1;
      coef_waddr = TW'(i);
      coef_wdata = CW'(cf[i]);
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  function automatic longint model(input int p, input bit right, output bit sat);
    longint s = 0;
    longint r;
    for (int k = 0; k < BRANCH; k++)
      s += cf[p + RATIO * k] * (right ? hr[k] : hl[k]);
    r = (s + (64'sd1 <<< (CW - 2))) >>> (CW - 1);
    sat = 1'b1;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    sat = 1'b0;
    return r;
  endfunction

  task automatic run_frame(input logic [DW-1:0] l, input logic [DW-1:0] r, input bit junk);
    int cyc = 0, got = 0;
    bit busy_ok = 1'b1;
    bit sat;
    longint e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    for (int k = BRANCH - 1; k > 0; k--) begin hl[k] = hl[k-1]; hr[k] = hr[k-1]; end
    hl[0] = $signed(l); hr[0] = $signed(r);
    @(posedge clk);
    @(negedge clk);
    if (junk) begin in_left = 16'h5a5a; in_right = 16'ha5a5; end
    else in_valid = 1'b0;
    while (got < 2 * RATIO) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (got >= 20) in_valid = 1'b0;
      if (out_valid) begin
        check("R2 phase", out_phase, got / 2);
        check("R2 chan", out_chan, got % 2);
        e = model(got / 2, got[0], sat);
        check(sat ? "R4 saturate" : "R3 value", $signed(out_data), e);
        got++;
      end
      if (in_ready) busy_ok = 1'b0;
    end
    check("R7 last strobe edge", cyc, LAT);
    check("R5 busy while computing", busy_ok, 1);
    @(negedge clk);
    check("R5 ready after last strobe", in_ready, 1);
  endtask

  initial begin
    for (int k = 0; k < BRANCH; k++) begin hl[k] = 0; hr[k] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset in_ready", in_ready, 0);
    rst = 1'b0;
    repeat (BRANCH - 1) @(negedge clk);
    check("R1 ready held during clear", in_ready, 0);
    @(negedge clk);
    check("R1 ready after clear", in_ready, 1);
    load_coefs(1'b0);
    for (int v = 0; v < NV; v++) begin
      if (v > 0 && VEC[v][1] != VEC[v-1][1]) load_coefs(VEC[v][1]); // R8 rewrite
      run_frame(VEC[v][33:18], VEC[v][17:2], VEC[v][0]);
    end
    // R6: no extra strobes after a busy period with in_valid high
    begin
      int stray = 0;
      repeat (20) begin @(negedge clk); if (out_valid) stray++; end
      check("R6 no stray strobes", stray, 0);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule